// File: doc/BRIEF.md
# Load-Adaptive Phase and Conduction-Mode Selector

This block picks the operating point of a two-phase interleaved converter from a digital estimate of total load current. Each time a new load sample arrives with its valid strobe, the block compares it against two pairs of programmable levels. The first pair governs whether the second phase switches. The second pair governs whether the secondary synchronous rectifiers are driven. With the rectifiers driven, the converter runs in continuous conduction. With them off, it runs in discontinuous conduction on diode freewheeling.

There are three operating modes, ordered by load. Heavy load uses both phases in continuous conduction. Light load uses one phase in continuous conduction. Extreme light load uses one phase in discontinuous conduction. Each level pair has a rising level and a falling level, which gives hysteresis. A move toward less switching only happens after a programmable number of consecutive qualifying samples. A move toward more capability happens on the first qualifying sample, so phase 2 returns quickly on a load step. The block also outputs an index that tells the loop which compensator coefficient set matches the current plant.

Top module: `phase_mode_mgr`

## Requirements
- R1: While and after reset, before any valid sample, ph2_en = 1, sr_en = 1 and coef_sel = 0 (two-phase continuous mode).
- R2: coef_sel encodes the mode as 0 = two-phase continuous, 1 = one-phase continuous and 2 = one-phase discontinuous. It changes on the same clock edge as ph2_en and sr_en. All three outputs reflect a sample on the edge that samples load_vld high.
- R3: In two-phase mode, a valid sample below shed_fall_lvl qualifies. On the N-th consecutive qualifying valid sample, the block moves to one-phase continuous mode (ph2_en = 0, sr_en = 1). N is shed_dwell, and a value of 0 acts as 1.
- R4: A valid sample that does not qualify restarts the consecutive count. Cycles with load_vld low neither advance nor break the count.
- R5: In one-phase continuous mode, on the N-th consecutive valid sample below dcm_fall_lvl, the block moves to discontinuous mode (sr_en = 0, ph2_en stays 0).
- R6: In either one-phase mode, the first valid sample at or above shed_rise_lvl moves the block straight to two-phase continuous mode. This drives ph2_en and sr_en both to 1 on the same edge.
- R7: In discontinuous mode, the first valid sample at or above dcm_rise_lvl and below shed_rise_lvl moves the block to one-phase continuous mode.
- R8: A sample at or above a falling level and below the matching rising level leaves the mode unchanged.
- R9: A downward move steps by exactly one mode. From two-phase mode, even a sample below dcm_fall_lvl leads only to one-phase continuous mode.
- R10: When load_vld is low, no output changes, whatever load_val holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_vld | input | 1 | Strobe marking a new load sample |
| load_val | input | LW | Total load-current estimate, unsigned |
| shed_rise_lvl | input | LW | Level at or above which phase 2 is re-enabled |
| shed_fall_lvl | input | LW | Level below which phase 2 may be shed |
| dcm_rise_lvl | input | LW | Level at or above which the rectifiers are re-enabled |
| dcm_fall_lvl | input | LW | Level below which the rectifiers may be turned off |
| shed_dwell | input | DW | Consecutive samples required for a downward move (0 acts as 1) |
| ph2_en | output | 1 | Phase 2 switching enable |
| sr_en | output | 1 | Secondary synchronous-rectifier drive enable |
| coef_sel | output | 2 | Compensator coefficient-set index |

## Verification
The phase re-enable and the rectifier re-enable both take effect on one edge when a sample jumps from discontinuous mode to above the phase-shedding rising level. The bench first drives the block into discontinuous mode with sub-threshold samples. It then sends one heavy sample and checks, one edge later, that ph2_en, sr_en and coef_sel read 1, 1 and 0 together. A second collision case sends a heavy sample while a downward count is part-way through. The bench checks that the upward move wins and that the pending count does not later cause a step down.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

  typedef enum logic [1:0] {
    MD_DUAL_CCM   = 2'd0,
    MD_SINGLE_CCM = 2'd1,
    MD_SINGLE_DCM = 2'd2
  } mode_e;

  typedef struct packed {
    logic heavy;       // sample at or above phase rising level
    logic below_shed;  // sample under phase falling level
    logic above_dcm;   // sample at or above rectifier rising level
    logic below_dcm;   // sample under rectifier falling level
  } lvl_flags_t;

  function automatic logic mode_ph2(mode_e m);
    return (m == MD_DUAL_CCM);
  endfunction

  function automatic logic mode_sr(mode_e m);
    return (m != MD_SINGLE_DCM);
  endfunction

endpackage

// File: rtl/pmm_cmp.sv
module pmm_cmp #(
  parameter int LW = 12
) (
  input  logic [LW-1:0]          sample,
  input  logic [LW-1:0]          shed_rise,
  input  logic [LW-1:0]          shed_fall,
  input  logic [LW-1:0]          dcm_rise,
  input  logic [LW-1:0]          dcm_fall,
  output pmm_pkg::lvl_flags_t    flags
);

  always_comb begin
    flags.heavy      = (sample >= shed_rise);
    flags.below_shed = (sample <  shed_fall);
    flags.above_dcm  = (sample >= dcm_rise);
    flags.below_dcm  = (sample <  dcm_fall);
  end

endmodule

// File: rtl/pmm_dwell.sv
module pmm_dwell #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_vld,
  input  logic          qual,
  input  logic          clear,
  input  logic [DW-1:0] limit,
  output logic          hit
);

  localparam int CNTW = DW + 1;

  logic [DW-1:0]   cnt_q;
  logic [CNTW-1:0] need;
  logic [CNTW-1:0] cnt_inc;

  always_comb begin
    need    = (limit == '0) ? CNTW'(1) : {1'b0, limit};
    cnt_inc = {1'b0, cnt_q} + CNTW'(1);
    hit     = sample_vld && qual && !clear && (cnt_inc >= need);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (sample_vld) begin
      if (!qual || clear || hit) cnt_q <= '0;
      else                       cnt_q <= cnt_inc[DW-1:0];
    end
  end

  // idle cycles neither advance nor clear the run (R4)
  p_idle_holds_run_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |=> $stable(cnt_q));

  // a non-qualifying sample restarts the run (R4)
  p_break_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && !qual) |=> (cnt_q == '0));

endmodule

// File: rtl/pmm_fsm.sv
module pmm_fsm (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_vld,
  input  pmm_pkg::lvl_flags_t  flags,
  input  logic                 dwell_hit,
  output logic                 qual_dn,
  output logic                 grow,
  output logic                 ph2_q,
  output logic                 sr_q,
  output logic [1:0]           coef_q
);
  import pmm_pkg::*;

  mode_e mode_q, up_tgt, dn_tgt, mode_d;

  always_comb begin
    up_tgt  = mode_q;
    dn_tgt  = mode_q;
    grow    = 1'b0;
    qual_dn = 1'b0;
    case (mode_q)
      MD_DUAL_CCM: begin
        qual_dn = flags.below_shed;
        dn_tgt  = MD_SINGLE_CCM;
      end
      MD_SINGLE_CCM: begin
        dn_tgt = MD_SINGLE_DCM;
        if (flags.heavy) begin
          grow   = 1'b1;
          up_tgt = MD_DUAL_CCM;
        end else begin
          qual_dn = flags.below_dcm;
        end
      end
      MD_SINGLE_DCM: begin
        if (flags.heavy) begin
          grow   = 1'b1;
          up_tgt = MD_DUAL_CCM;
        end else if (flags.above_dcm) begin
          grow   = 1'b1;
          up_tgt = MD_SINGLE_CCM;
        end
      end
      default: begin
        grow   = 1'b1;
        up_tgt = MD_DUAL_CCM;
      end
    endcase

    if (!sample_vld)    mode_d = mode_q;
    else if (grow)      mode_d = up_tgt;
    else if (dwell_hit) mode_d = dn_tgt;
    else                mode_d = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_DUAL_CCM;
      ph2_q  <= 1'b1;
      sr_q   <= 1'b1;
      coef_q <= 2'd0;
    end else begin
      mode_q <= mode_d;
      ph2_q  <= mode_ph2(mode_d);
      sr_q   <= mode_sr(mode_d);
      coef_q <= mode_d;
    end
  end

  // index 0 exactly when both phases run (R2)
  p_coef_vs_phase_r2: assert property (@(posedge clk) disable iff (rst)
    (coef_q == 2'd0) == ph2_q);

  // rectifiers off only in single-phase operation (R5)
  p_dcm_single_r5: assert property (@(posedge clk) disable iff (rst)
    !sr_q |-> !ph2_q);

  // shedding phase 2 never also drops the rectifiers (R9)
  p_one_step_down_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(ph2_q) && !ph2_q) |-> sr_q);

  // no sample, no mode change (R10)
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |=> $stable(mode_q));

endmodule

// File: rtl/phase_mode_mgr.sv
module phase_mode_mgr #(
  parameter int LW = 12,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_vld,
  input  logic [LW-1:0] load_val,
  input  logic [LW-1:0] shed_rise_lvl,
  input  logic [LW-1:0] shed_fall_lvl,
  input  logic [LW-1:0] dcm_rise_lvl,
  input  logic [LW-1:0] dcm_fall_lvl,
  input  logic [DW-1:0] shed_dwell,
  output logic          ph2_en,
  output logic          sr_en,
  output logic [1:0]    coef_sel
);

  pmm_pkg::lvl_flags_t flags;
  logic qual_dn, grow, dwell_hit;

  pmm_cmp #(.LW(LW)) u_cmp (
    .sample    (load_val),
    .shed_rise (shed_rise_lvl),
    .shed_fall (shed_fall_lvl),
    .dcm_rise  (dcm_rise_lvl),
    .dcm_fall  (dcm_fall_lvl),
    .flags     (flags)
  );

  pmm_dwell #(.DW(DW)) u_dwell (
    .clk        (clk),
    .rst        (rst),
    .sample_vld (load_vld),
    .qual       (qual_dn),
    .clear      (grow),
    .limit      (shed_dwell),
    .hit        (dwell_hit)
  );

  pmm_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sample_vld (load_vld),
    .flags      (flags),
    .dwell_hit  (dwell_hit),
    .qual_dn    (qual_dn),
    .grow       (grow),
    .ph2_q      (ph2_en),
    .sr_q       (sr_en),
    .coef_q     (coef_sel)
  );

  // a heavy sample restores phase 2 on the next edge (R6)
  p_fast_regrow_r6: assert property (@(posedge clk) disable iff (rst)
    (load_vld && (load_val >= shed_rise_lvl)) |=> (ph2_en && sr_en));

endmodule

// File: tb/sim_phase_mode_mgr.sv
`timescale 1ns/1ps
module sim_phase_mode_mgr;
  localparam int LW = 12;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_vld = 1'b0;
  logic [LW-1:0] load_val = '0;
  logic [LW-1:0] shed_rise_lvl = 12'd1000;
  logic [LW-1:0] shed_fall_lvl = 12'd800;
  logic [LW-1:0] dcm_rise_lvl  = 12'd300;
  logic [LW-1:0] dcm_fall_lvl  = 12'd200;
  logic [DW-1:0] shed_dwell    = 4'd3;
  logic          ph2_en, sr_en;
  logic [1:0]    coef_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_mode_mgr #(.LW(LW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .load_vld(load_vld), .load_val(load_val),
    .shed_rise_lvl(shed_rise_lvl), .shed_fall_lvl(shed_fall_lvl),
    .dcm_rise_lvl(dcm_rise_lvl), .dcm_fall_lvl(dcm_fall_lvl),
    .shed_dwell(shed_dwell), .ph2_en(ph2_en), .sr_en(sr_en), .coef_sel(coef_sel)
  );

  task automatic chk(string tag, logic e_ph2, logic e_sr, logic [1:0] e_coef);
    checks++;
    if ({ph2_en, sr_en, coef_sel} !== {e_ph2, e_sr, e_coef}) begin
      errors++;
      $display("FAIL %s: got ph2=%0b sr=%0b coef=%0d, expected ph2=%0b sr=%0b coef=%0d",
               tag, ph2_en, sr_en, coef_sel, e_ph2, e_sr, e_coef);
    end
  endtask

  // one valid sample; returns at the negedge after the sampling edge
  task automatic send(int v);
    @(negedge clk);
    load_val = LW'(v);
    load_vld = 1'b1;
    @(negedge clk);
    load_vld = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_dual();
    send(1500);
  endtask

  task automatic go_single();
    go_dual();
    for (int i = 0; i < 3; i++) send(700);
  endtask

  task automatic go_dcm();
    go_single();
    for (int i = 0; i < 3; i++) send(100);
  endtask

  task automatic t_reset();
    chk("R1 during reset", 1, 1, 0);
    @(negedge clk); rst = 1'b0;
    idle(2);
    chk("R1 after reset", 1, 1, 0);
  endtask

  task automatic t_shed();
    go_dual();
    send(700); chk("R3 one sample", 1, 1, 0);
    send(700); chk("R3 two samples", 1, 1, 0);
    send(700); chk("R3 shed on third, R2 coef 1", 0, 1, 1);
  endtask

  task automatic t_restart();
    go_dual();
    send(700); send(700);
    send(900); chk("R4 break sample", 1, 1, 0);
    send(700); send(700); chk("R4 run restarted", 1, 1, 0);
    idle(5);
    send(700); chk("R4 idle did not break run", 0, 1, 1);
  endtask

  task automatic t_no_skip();
    go_dual();
    send(100); send(100);
    send(100); chk("R9 only one step down", 0, 1, 1);
    send(100); send(100); chk("R5 two samples", 0, 1, 1);
    send(100); chk("R5 enter discontinuous", 0, 0, 2);
  endtask

  task automatic t_hyst();
    go_single();
    send(950); chk("R8 between phase levels", 0, 1, 1);
    send(250); chk("R8 between rectifier levels", 0, 1, 1);
    go_dual();
    send(850); send(850); send(850); chk("R8 above phase falling level", 1, 1, 0);
    go_dcm();
    send(250); chk("R8 discontinuous holds", 0, 0, 2);
  endtask

  task automatic t_grow();
    go_single();
    send(1000); chk("R6 one-phase to dual at level", 1, 1, 0);
    go_dcm();
    send(1500); chk("R6 discontinuous jumps to dual", 1, 1, 0);
    go_dcm();
    send(300); chk("R7 discontinuous to continuous", 0, 1, 1);
    // collision: heavy sample during a pending downward run
    send(100); send(100);
    send(1200); chk("R6 grow beats pending run", 1, 1, 0);
    send(700); chk("R4 run cleared by grow", 1, 1, 0);
  endtask

  task automatic t_idle();
    go_dcm();
    @(negedge clk); load_val = 12'd4000;
    idle(6);
    chk("R10 idle with heavy value", 0, 0, 2);
    go_dual();
    @(negedge clk); load_val = 12'd0;
    idle(6);
    chk("R10 idle with zero value", 1, 1, 0);
  endtask

  task automatic t_dwell_zero();
    shed_dwell = 4'd0;
    go_dual();
    send(700); chk("R3 zero dwell acts as one", 0, 1, 1);
    send(100); chk("R5 zero dwell acts as one", 0, 0, 2);
    shed_dwell = 4'd1;
    go_dual();
    send(700); chk("R3 dwell of one", 0, 1, 1);
    shed_dwell = 4'd3;
  endtask

  initial begin
    idle(3);
    t_reset();
    t_shed();
    t_restart();
    t_no_skip();
    t_hyst();
    t_grow();
    t_idle();
    t_dwell_zero();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule